// File: doc/BRIEF.md
# Folded Butterfly Switching Network with U-Turn Shortcuts

This block is a statically configured interconnect for a small programmable fabric. N data lanes enter at the bottom, climb through butterfly stages toward a single central stage, and descend through mirror-image stages to N output lanes. The network is folded at its central stage. At a climbing stage S a "source" switch passes its output both upward and sideways to its partner "target" switch on the descending side. That target switch can take the sideways (U-turn) value instead of the value arriving from above. A connection whose endpoints all sit inside one aligned group of 2^S lanes can therefore reverse direction at stage S. It never touches the stages above S. Stage depth tracks how far apart the endpoints are.

All switch settings sit in one serial configuration chain, which is loaded bit by bit while the fabric is idle. The data path from `din` to `dout` is purely combinational; only the chain is clocked. A build-time parameter selects where shortcuts exist: at every climbing stage, or only at odd-numbered climbing stages. The even stages then have plain target switches and a shorter chain. With L = log2(N), a route that reverses at stage S crosses 2S switch stages. A route through the centre crosses 2L-1.

Top module: `fold_uturn_net`

## Requirements
- R1: After reset every configuration bit is 0. With every bit at 0, output lane i carries input lane i for all i.
- R2: While `cfg_en` is high, each rising clock edge moves the chain one place toward index 0 and places `cfg_in` at the highest index. The first bit shifted in therefore reaches index 0 after a full load. While `cfg_en` is low the chain, and hence the routing, does not change.
- R3: Chain layout for N=8, L=3. Climbing stage s (s=1,2) lane i uses bit (s-1)*8+i, and the central stage lane i uses bit 16+i. The descending stages follow, stage 2 first and then stage 1. Each descending stage is a list of elements ordered by their lower lane, where an element pairs lanes that differ in bit s-1. An element holds its cross bits (lower lane, upper lane) and then, if it has a shortcut, its U-turn bits (lower lane, upper lane): 4 bits with a shortcut, 2 without.
- R4: In a climbing or central stage s, a lane whose cross bit is 1 takes the value of the lane whose index differs in bit s-1. Otherwise it keeps its own lane's value.
- R5: In a descending stage S with a shortcut, a lane whose U-turn bit is 1 takes climbing stage S's output on the same lane, whatever its cross bit says. Otherwise the cross bit selects the partner lane or the same lane from the stage above.
- R6: In full mode every climbing stage 1..L-1 has shortcuts (56 chain bits for N=8). In odd-only mode only odd stages have them (48 chain bits for N=8), and the even descending stages have 2 bits per element.
- R7: A route that reverses at stage S depends only on the settings of stages up to S. Changing any central-stage setting leaves its output unchanged.
- R8: A connection between lanes in different halves of the network passes through the central stage and arrives unchanged on the target lane.
- R9: One input can drive several outputs at once, some through shortcuts at different stages and some through the central stage, with no interference between the branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset, clears the chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration bit |
| din | input | N_PORTS*DATA_W | Input lanes, lane i at bits i*DATA_W upward |
| dout | output | N_PORTS*DATA_W | Output lanes, same packing as din |

## Verification
The checks on the data path sample `dout` at the clock edge. They assume `din` is steady around that edge, because the path from `din` to `dout` has no register. The bench changes `din` and the chain inputs only on the falling edge, so every sampled value has settled. The properties on the chain assume that `cfg_en` and `cfg_in` are steady at each rising edge, which the same falling-edge driving ensures. Expected outputs come from a lane-by-lane trace of each stage, built from the layout and select rules above. Each route is also checked against a hand-derived destination.

// File: rtl/fold_net_pkg.sv
package fold_net_pkg;

    typedef enum logic {
        BYP_FULL = 1'b0,
        BYP_ODD  = 1'b1
    } bypass_mode_e;

    // shortcut present at climbing stage s
    function automatic bit turn_enabled(int s, bypass_mode_e mode);
        return (mode == BYP_FULL) || ((s % 2) == 1);
    endfunction

    // chain bits per lane at a descending stage
    function automatic int dn_width(int s, bypass_mode_e mode);
        return turn_enabled(s, mode) ? 2 : 1;
    endfunction

    // first chain bit of descending stage s
    function automatic int dn_offset(int s, int n, int lvl, bypass_mode_e mode);
        int off;
        off = lvl * n;
        for (int t = lvl - 1; t > s; t--) begin
            off += n * dn_width(t, mode);
        end
        return off;
    endfunction

    function automatic int cfg_total(int n, int lvl, bypass_mode_e mode);
        return dn_offset(0, n, lvl, mode);
    endfunction

endpackage

// File: rtl/fold_cfg_chain.sv
module fold_cfg_chain #(
    parameter int TOT = 56
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           shift_in,
    output logic [TOT-1:0] cfg_o
);

    typedef struct packed {
        logic [TOT-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {shift_in, st_q.bits[TOT-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.bits;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg_o[TOT-1] == $past(shift_in)));  // R2
    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg_o[TOT-2:0] == $past(cfg_o[TOT-1:1])));  // R2
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg_o));  // R2

endmodule

// File: rtl/fold_src_stage.sv
module fold_src_stage #(
    parameter int N   = 8,
    parameter int W   = 8,
    parameter int BIT = 0
) (
    input  logic [N*W-1:0] lanes_i,
    input  logic [N-1:0]   cross_i,
    output logic [N*W-1:0] lanes_o
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam int PART = i ^ (1 << BIT);
        assign lanes_o[i*W +: W] = cross_i[i] ? lanes_i[PART*W +: W]
                                              : lanes_i[i*W +: W];
    end

endmodule

// File: rtl/fold_tgt_stage.sv
module fold_tgt_stage #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter int BIT  = 0,
    parameter bit TURN = 1'b1
) (
    input  logic [N*W-1:0]               above_i,
    input  logic [N*W-1:0]               turn_i,
    input  logic [N*(TURN ? 2 : 1)-1:0]  cfg_i,
    output logic [N*W-1:0]               lanes_o
);

    localparam int EW = TURN ? 4 : 2;

    for (genvar j = 0; j < N / 2; j++) begin : g_elem
        for (genvar k = 0; k < 2; k++) begin : g_side
            localparam int LANE = ((j >> BIT) << (BIT + 1))
                                | (j & ((1 << BIT) - 1))
                                | (k << BIT);
            localparam int PART = LANE ^ (1 << BIT);
            logic sel_x, sel_t;
            assign sel_x = cfg_i[j*EW + k];
            if (TURN) begin : g_turn
                assign sel_t = cfg_i[j*EW + 2 + k];
            end else begin : g_plain
                assign sel_t = 1'b0;
            end
            always_comb begin
                if (sel_t) begin
                    lanes_o[LANE*W +: W] = turn_i[LANE*W +: W];
                end else if (sel_x) begin
                    lanes_o[LANE*W +: W] = above_i[PART*W +: W];
                end else begin
                    lanes_o[LANE*W +: W] = above_i[LANE*W +: W];
                end
            end
        end
    end

endmodule

// File: rtl/fold_uturn_net.sv
module fold_uturn_net
    import fold_net_pkg::*;
#(
    parameter int           N_PORTS = 8,
    parameter int           DATA_W  = 8,
    parameter bypass_mode_e BYPASS  = BYP_FULL
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en,
    input  logic                      cfg_in,
    input  logic [N_PORTS*DATA_W-1:0] din,
    output logic [N_PORTS*DATA_W-1:0] dout
);

    localparam int LVL      = $clog2(N_PORTS);
    localparam int BUS      = N_PORTS * DATA_W;
    localparam int CFG_BITS = cfg_total(N_PORTS, LVL, BYPASS);

    logic [CFG_BITS-1:0] cfg_q;
    logic [BUS-1:0]      up_w [0:LVL];
    logic [BUS-1:0]      dn_w [1:LVL];

    fold_cfg_chain #(.TOT(CFG_BITS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .shift_in (cfg_in),
        .cfg_o    (cfg_q)
    );

    assign up_w[0] = din;

    // climbing stages 1..LVL-1 and the central stage LVL
    for (genvar s = 1; s <= LVL; s++) begin : g_up
        fold_src_stage #(.N(N_PORTS), .W(DATA_W), .BIT(s - 1)) u_src (
            .lanes_i (up_w[s-1]),
            .cross_i (cfg_q[(s-1)*N_PORTS +: N_PORTS]),
            .lanes_o (up_w[s])
        );
    end

    assign dn_w[LVL] = up_w[LVL];

    for (genvar s = 1; s < LVL; s++) begin : g_dn
        localparam bit TURN = turn_enabled(s, BYPASS);
        localparam int OFF  = dn_offset(s, N_PORTS, LVL, BYPASS);
        localparam int CW   = N_PORTS * dn_width(s, BYPASS);
        fold_tgt_stage #(.N(N_PORTS), .W(DATA_W), .BIT(s - 1), .TURN(TURN)) u_tgt (
            .above_i (dn_w[s+1]),
            .turn_i  (up_w[s]),
            .cfg_i   (cfg_q[OFF +: CW]),
            .lanes_o (dn_w[s])
        );
    end

    assign dout = dn_w[1];

    AST_STRAIGHT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |-> (dout == din));  // R1

    if (LVL > 1) begin : g_chk_turn1
        localparam int OFF1 = dn_offset(1, N_PORTS, LVL, BYPASS);
        for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
            localparam int TB = OFF1 + 4 * (i / 2) + 2 + (i % 2);
            AST_TURN_STAGE1_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_q[TB] |-> (dout[i*DATA_W +: DATA_W] == up_w[1][i*DATA_W +: DATA_W]));  // R7
        end
    end

endmodule

// File: tb/fold_uturn_net_test.sv
module fold_uturn_net_test;
    import fold_net_pkg::*;

    localparam int N     = 8;
    localparam int W     = 8;
    localparam int TOT_F = 56;
    localparam int TOT_H = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_f = 1'b0;
    logic        en_h = 1'b0;
    logic        cfg_in = 1'b0;
    logic [63:0] din = '0;
    logic [63:0] dout_f, dout_h;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    fold_uturn_net #(.N_PORTS(N), .DATA_W(W), .BYPASS(BYP_FULL)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(en_f), .cfg_in(cfg_in),
        .din(din), .dout(dout_f));

    fold_uturn_net #(.N_PORTS(N), .DATA_W(W), .BYPASS(BYP_ODD)) uut_odd (
        .clk(clk), .rst_n(rst_n), .cfg_en(en_h), .cfg_in(cfg_in),
        .din(din), .dout(dout_h));

    // R3 layout, written from the requirement
    function automatic int up_bit(int s, int i);
        return (s - 1) * 8 + i;
    endfunction

    function automatic int dn_bit(int s, int i, bit half, bit turn);
        int base, ew, j, k;
        if (half) base = (s == 2) ? 24 : 32;
        else      base = (s == 2) ? 24 : 40;
        ew = (half && s == 2) ? 2 : 4;
        j  = ((i >> s) << (s - 1)) | (i & ((1 << (s - 1)) - 1));
        k  = (i >> (s - 1)) & 1;
        return base + j * ew + (turn ? 2 : 0) + k;
    endfunction

    function automatic logic [63:0] ref_out(logic [63:0] cfg, logic [63:0] d, bit half);
        logic [7:0] cur [8];
        logic [7:0] nxt [8];
        logic [7:0] up1 [8];
        logic [7:0] up2 [8];
        logic [63:0] r;
        bit tb;
        for (int i = 0; i < 8; i++) cur[i] = d[i*8 +: 8];
        for (int s = 1; s <= 3; s++) begin
            for (int i = 0; i < 8; i++)
                nxt[i] = cfg[up_bit(s, i)] ? cur[i ^ (1 << (s - 1))] : cur[i];
            cur = nxt;
            if (s == 1) up1 = cur;
            if (s == 2) up2 = cur;
        end
        for (int s = 2; s >= 1; s--) begin
            for (int i = 0; i < 8; i++) begin
                tb = (half && s == 2) ? 1'b0 : cfg[dn_bit(s, i, half, 1'b1)];
                if (tb)                           nxt[i] = (s == 2) ? up2[i] : up1[i];
                else if (cfg[dn_bit(s, i, half, 1'b0)]) nxt[i] = cur[i ^ (1 << (s - 1))];
                else                              nxt[i] = cur[i];
            end
            cur = nxt;
        end
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = cur[i];
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lane(logic [63:0] v, int i);
        return v[i*8 +: 8];
    endfunction

    task automatic set_din(logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < 8; i++) din[i*8 +: 8] = seed + 8'(i * 17);
        #1;
    endtask

    task automatic load(bit half, logic [63:0] v);
        int n;
        n = half ? TOT_H : TOT_F;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_in = v[k];
            if (half) en_h = 1'b1; else en_f = 1'b1;
        end
        @(negedge clk);
        en_f = 1'b0;
        en_h = 1'b0;
        cfg_in = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_din(8'h11);
        check("R1 identity full", dout_f, din);
        check("R1 identity odd", dout_h, din);
        set_din(8'hC3);
        check("R1 identity pattern2", dout_f, din);
    endtask

    task automatic t_local_turns;
        logic [63:0] v;
        v = '0;
        v[up_bit(1, 1)] = 1'b1;
        v[dn_bit(1, 1, 1'b0, 1'b1)] = 1'b1;
        load(1'b0, v);
        set_din(8'h20);
        check("R5 turn S1 in0->out1", lane(dout_f, 1), lane(din, 0));
        check("R5 turn S1 trace", dout_f, ref_out(v, din, 1'b0));
        v = '0;
        v[up_bit(1, 1)] = 1'b1;
        v[up_bit(2, 3)] = 1'b1;
        v[dn_bit(2, 3, 1'b0, 1'b1)] = 1'b1;
        v[dn_bit(2, 3, 1'b0, 1'b0)] = 1'b1;  // cross also set: U-turn wins
        load(1'b0, v);
        set_din(8'h40);
        check("R5 turn S2 in0->out3", lane(dout_f, 3), lane(din, 0));
        check("R3 turn S2 trace", dout_f, ref_out(v, din, 1'b0));
        // R7: central settings must not matter for the stage-2 route
        for (int i = 16; i < 24; i++) v[i] = 1'b1;
        load(1'b0, v);
        set_din(8'h40);
        check("R7 central ignored out3", lane(dout_f, 3), lane(din, 0));
        check("R7 trace", dout_f, ref_out(v, din, 1'b0));
    endtask

    task automatic t_full_depth;
        logic [63:0] v;
        v = '0;
        v[up_bit(1, 1)] = 1'b1;
        v[up_bit(2, 3)] = 1'b1;
        v[up_bit(3, 7)] = 1'b1;
        load(1'b0, v);
        set_din(8'h05);
        check("R8 in0->out7 via centre", lane(dout_f, 7), lane(din, 0));
        check("R4 full depth trace", dout_f, ref_out(v, din, 1'b0));
    endtask

    task automatic t_multicast;
        logic [63:0] v;
        logic [63:0] snap;
        v = '0;
        v[up_bit(1, 1)] = 1'b1;
        v[up_bit(2, 3)] = 1'b1;
        v[up_bit(3, 7)] = 1'b1;
        v[dn_bit(1, 1, 1'b0, 1'b1)] = 1'b1;
        v[dn_bit(2, 3, 1'b0, 1'b1)] = 1'b1;
        load(1'b0, v);
        set_din(8'h9A);
        check("R9 branch out1", lane(dout_f, 1), lane(din, 0));
        check("R9 branch out3", lane(dout_f, 3), lane(din, 0));
        check("R9 branch out7", lane(dout_f, 7), lane(din, 0));
        check("R9 trace", dout_f, ref_out(v, din, 1'b0));
        // R2: chain holds while enable is low
        snap = dout_f;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_in = k[0];
        end
        #1;
        check("R2 hold", dout_f, snap);
    endtask

    task automatic t_odd_mode;
        logic [63:0] v;
        v = '0;
        v[up_bit(1, 3)] = 1'b1;
        v[dn_bit(1, 3, 1'b1, 1'b1)] = 1'b1;
        v[dn_bit(2, 7, 1'b1, 1'b0)] = 1'b1;
        load(1'b1, v);
        set_din(8'h33);
        check("R6 odd turn S1 in2->out3", lane(dout_h, 3), lane(din, 2));
        check("R6 odd stage2 cross in5->out7", lane(dout_h, 7), lane(din, 5));
        check("R6 odd trace", dout_h, ref_out(v, din, 1'b1));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_local_turns();
        t_full_depth();
        t_multicast();
        t_odd_mode();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule